// File: doc/BRIEF.md
# Dual-Line Channel-Completion Interrupt Aggregator

This block collects one completion pulse per transfer channel into a shared sticky status word and fans that word out to two independent interrupt lines. Each line has its own enable mask and its own force mask. A line's masked status is formed from the raw word ORed with that line's force mask, then gated by that line's enable mask. The line's interrupt output is high whenever any bit of its masked status is set.

Software reaches the block through a small word-addressed register port with a one-cycle registered read. It reads the raw word, each line's enable, force and masked status, and acknowledges channels by writing ones. A write of ones to the raw word, to a line's raw alias, or to either line's masked status clears the matching raw bits. Forced bits appear only in the masked status and never disturb the raw word. A channel that completes in the same cycle as its acknowledge keeps its bit set, so no completion is lost.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: A high bit on `chan_done` sets the matching raw status bit at the next clock edge. The bit stays set until it is cleared.
- R3: Word address 0 reads the raw status. Word address 4+4k (raw alias of line k) reads the same value. A write to either address clears each raw bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R4: Word address 7+4k reads line k's masked status. A write there clears the raw bits written as 1, whatever the enable masks hold.
- R5: When a completion pulse and a clear target the same bit in the same cycle, the bit ends up set.
- R6: Line k's masked status equals (raw OR force_k) AND enable_k. The two lines are computed independently from their own masks.
- R7: `irq_out[k]` is the OR of line k's masked status, registered. It follows a change of that status one clock later.
- R8: Word address 6+4k is line k's force mask. Its bits hold until software writes them to zero, and forcing never changes the raw status.
- R9: Word address 5+4k is line k's enable mask. Both enable and force registers keep only the low 16 bits of the write data, and their upper bits read zero.
- R10: Word addresses 1, 2 and 3 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_done | input | NUM_CH | One-cycle completion pulses, one per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | High the cycle after a read strobe |
| irq_out | output | NUM_LINES | Registered interrupt lines |

## Verification
The hardest case to reach is the collision in which a completion pulse and an acknowledge write land on the same raw bit in the same cycle. The bench has a dedicated task that raises `chan_done` and the write strobe together before a single edge. It then reads the raw word to confirm that the bit survived, while another bit in the same write is cleared. A second difficult case is a forced bit that raises one line but not the other without touching the raw word. The bench reaches it by giving the two lines disjoint enable masks and then reading both masked words and the raw word back to back.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // slot inside each group of four word addresses
  typedef enum logic [1:0] {
    SLOT_RAW = 2'd0,
    SLOT_EN  = 2'd1,
    SLOT_FRC = 2'd2,
    SLOT_MSK = 2'd3
  } slot_e;

  localparam int SLOTS_PER_GROUP = 4;
endpackage

// File: rtl/irq_raw_status.sv
module irq_raw_status #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] raw_o
);
  logic [NUM_CH-1:0] raw_q;

  // set has priority over clear for the same bit
  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= (raw_q & ~clr_i) | set_i;
  end

  assign raw_o = raw_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i))); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    ((raw_q & ~$past(raw_q) & ~$past(set_i)) == '0)); // R2

  AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((~raw_q & $past(raw_q) & ~$past(clr_i)) == '0)); // R3
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] raw_i,
  input  logic              en_we,
  input  logic              frc_we,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] frc_o,
  output logic [NUM_CH-1:0] masked_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] frc_q;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      frc_q <= '0;
    end else begin
      if (en_we)  en_q  <= wdata_i;
      if (frc_we) frc_q <= wdata_i;
    end
  end

  assign masked_o = (raw_i | frc_q) & en_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked_o;
  end

  assign en_o  = en_q;
  assign frc_o = frc_q;
  assign irq_o = irq_q;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (|$past(en_q))); // R6

  AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(frc_we) |-> $stable(frc_q)); // R8

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(en_we) |-> $stable(en_q)); // R9
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_LINES = 2,
  parameter int DATA_W    = 32,
  localparam int ADDR_W   = $clog2(SLOTS_PER_GROUP * (NUM_LINES + 1))
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CH-1:0]    chan_done,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 reg_rvalid,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int GRP_W = ADDR_W - 2;

  logic [GRP_W-1:0]  grp;
  slot_e             slot;
  logic [NUM_CH-1:0] wbits;
  logic              unused_wdata_hi;
  logic              grp_is_line;
  logic              ack_hit;
  logic [NUM_CH-1:0] clr_bits;
  logic [NUM_CH-1:0] raw;

  logic [NUM_CH-1:0] en_a     [NUM_LINES];
  logic [NUM_CH-1:0] frc_a    [NUM_LINES];
  logic [NUM_CH-1:0] masked_a [NUM_LINES];

  assign grp             = reg_addr[ADDR_W-1:2];
  assign slot            = slot_e'(reg_addr[1:0]);
  assign wbits           = reg_wdata[NUM_CH-1:0];
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_CH];
  assign grp_is_line     = (grp != '0) && (int'(grp) <= NUM_LINES);

  // acknowledge: raw word, any raw alias, or any masked status word
  always_comb begin
    ack_hit = 1'b0;
    if (reg_wr) begin
      if (grp == '0) ack_hit = (slot == SLOT_RAW);
      else if (grp_is_line) ack_hit = (slot == SLOT_RAW) || (slot == SLOT_MSK);
    end
  end

  assign clr_bits = ack_hit ? wbits : '0;

  irq_raw_status #(.NUM_CH(NUM_CH)) u_raw (
    .clk   (clk),
    .rst   (rst),
    .set_i (chan_done),
    .clr_i (clr_bits),
    .raw_o (raw)
  );

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic sel;
    assign sel = reg_wr && (grp == GRP_W'(k + 1));

    irq_line #(.NUM_CH(NUM_CH)) u_line (
      .clk      (clk),
      .rst      (rst),
      .raw_i    (raw),
      .en_we    (sel && (slot == SLOT_EN)),
      .frc_we   (sel && (slot == SLOT_FRC)),
      .wdata_i  (wbits),
      .en_o     (en_a[k]),
      .frc_o    (frc_a[k]),
      .masked_o (masked_a[k]),
      .irq_o    (irq_out[k])
    );
  end

  // read selection
  logic [NUM_CH-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (grp == '0) begin
      if (slot == SLOT_RAW) rd_val = raw;
    end else begin
      for (int k = 0; k < NUM_LINES; k++) begin
        if (grp == GRP_W'(k + 1)) begin
          case (slot)
            SLOT_RAW: rd_val = raw;
            SLOT_EN:  rd_val = en_a[k];
            SLOT_FRC: rd_val = frc_a[k];
            default:  rd_val = masked_a[k];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= DATA_W'(rd_val);
    end
  end

  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid); // R1

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rvalid |-> (reg_rdata[DATA_W-1:NUM_CH] == '0)); // R9
endmodule

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int NL  = 2;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NCH-1:0] chan_done = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          reg_rvalid;
  logic [NL-1:0] irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  exp_t sb_q[$];

  logic [NCH-1:0] m_raw;
  logic [NCH-1:0] m_en  [NL];
  logic [NCH-1:0] m_frc [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_agg u_dma_irq_agg (
    .clk(clk), .rst(rst), .chan_done(chan_done), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_out(irq_out)
  );

  function automatic logic [NCH-1:0] m_masked(int k);
    return (m_raw | m_frc[k]) & m_en[k];
  endfunction

  function automatic logic [31:0] m_read(int a);
    int g = a / 4;
    int s = a % 4;
    if (g == 0) return (s == 0) ? 32'(m_raw) : 32'h0;
    if (g > NL) return 32'h0;
    case (s)
      0: return 32'(m_raw);
      1: return 32'(m_en[g-1]);
      2: return 32'(m_frc[g-1]);
      default: return 32'(m_masked(g-1));
    endcase
  endfunction

  function automatic void m_write(int a, logic [31:0] d);
    int g = a / 4;
    int s = a % 4;
    if (g == 0) begin
      if (s == 0) m_raw = m_raw & ~d[NCH-1:0];
    end else if (g <= NL) begin
      case (s)
        0, 3: m_raw = m_raw & ~d[NCH-1:0];
        1: m_en[g-1]  = d[NCH-1:0];
        default: m_frc[g-1] = d[NCH-1:0];
      endcase
    end
  endfunction

  // monitor: pop and compare read results
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      exp_t e;
      n_checks++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data: actual %h expected none", reg_rdata);
      end else begin
        e = sb_q.pop_front();
        if (reg_rdata !== e.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", e.tag, reg_rdata, e.exp);
        end
      end
    end
  end

  task automatic rd(int a, string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(a);
    sb_q.push_back('{exp: m_read(a), tag: tag});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic pulse(logic [NCH-1:0] p);
    @(negedge clk);
    chan_done = p;
    @(negedge clk);
    chan_done = '0;
    m_raw = m_raw | p;
  endtask

  task automatic pulse_and_ack(int a, logic [NCH-1:0] p, logic [31:0] d);
    @(negedge clk);
    chan_done = p; reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    chan_done = '0; reg_wr = 1'b0;
    m_write(a, d);
    m_raw = m_raw | p;
  endtask

  task automatic chk_irq(string tag);
    logic [NL-1:0] e;
    @(negedge clk);
    for (int k = 0; k < NL; k++) e[k] = |m_masked(k);
    n_checks++;
    if (irq_out !== e) begin
      n_fail++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq_out, e);
    end
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_fail++; n_checks++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    m_raw = '0;
    for (int k = 0; k < NL; k++) begin m_en[k] = '0; m_frc[k] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R10 holes
    for (int a = 0; a < 12; a++) rd(a, (a inside {1,2,3}) ? "R10 hole" : "R1 reset");
    chk_irq("R1");

    // R2 set
    pulse(16'h0005);
    rd(0, "R2 raw set");
    rd(8, "R3 alias line1");
    rd(0, "R2 sticky");

    // R3 clear via raw, zero bits no effect
    wr(0, 32'h0000_0001);
    rd(0, "R3 w1c raw");
    wr(0, 32'h0);
    rd(0, "R3 zero write");

    // R9 enables, R6 masked, R7 irq
    wr(5, 32'h0000_00F0);
    wr(9, 32'h0000_0004);
    rd(5, "R9 en0 readback");
    rd(9, "R9 en1 readback");
    rd(7, "R6 masked0");
    rd(11, "R6 masked1");
    chk_irq("R7 line1 only");

    // R8 force on line0 only
    wr(6, 32'h0000_0010);
    rd(7, "R8 forced masked0");
    rd(11, "R6 masked1 unaffected");
    rd(0, "R8 raw unchanged");
    chk_irq("R7 both");

    // R4 clear via masked status of line1
    wr(11, 32'h0000_0004);
    rd(0, "R4 masked w1c");
    chk_irq("R7 after ack");

    // R4 masked write clears bit not enabled
    pulse(16'h0002);
    wr(7, 32'h0000_0002);
    rd(0, "R4 clear unenabled");

    // R5 collision, plus a second bit cleared
    pulse(16'h0400);
    pulse_and_ack(0, 16'h0300, 32'h0000_0700);
    rd(0, "R5 set wins");

    // R10 write to hole
    wr(2, 32'hFFFF_FFFF);
    rd(2, "R10 hole read");
    rd(0, "R10 raw untouched");
    rd(5, "R10 en untouched");

    // R8 force persists, then cleared
    rd(6, "R8 force holds");
    wr(6, 32'h0);
    rd(7, "R8 force cleared");
    chk_irq("R7 after unforce");

    // R9 upper bits dropped
    wr(9, 32'hFFFF_FFFF);
    rd(9, "R9 upper zero");
    rd(11, "R6 masked1 full");
    chk_irq("R7 line1 raw");

    // R3 clear via line0 raw alias
    wr(4, 32'h0000_0100);
    rd(0, "R3 alias w1c");
    rd(4, "R3 alias read");

    finish_run();
  end
endmodule